// File: doc/BRIEF.md
# Dual-Rail Power-Good Monitor with Minimum Low Stretch

This block drives an active-low, open-drain power-good line for two buck converter rails. Each rail has an analog comparator that reports whether its output is above the good threshold, which is 89% of that rail's nominal voltage. The block samples these comparator flags and a master enable. It releases the line only while both rails are good and the master enable is high.

When the line has been pulled low, it stays low for a guaranteed minimum time, 10 µs by default, even if the rails recover sooner. That time is counted in clock cycles, and the count comes from the clock frequency parameter. The stretch counter is held at its full value for as long as a rail is bad. It counts down only once both rails are good again, so a failure during the stretch restarts the full wait.

Only the two buck rails feed the decision. The boost rail and the always-on rails are not monitored.

Top module: `pg_monitor`

## Requirements
- R1: `pg_sink` is the open-drain enable. A value of 1 sinks the line to logic low (not good). A value of 0 releases it (good).
- R2: `pg_sink` is 0 only while both bits of `rail_good` and `master_on` are 1 and the stretch has expired. Bit 0 is the first buck rail and bit 1 is the second.
- R3: If any rail flag drops before rising clock edge k, `pg_sink` is 1 after edge k+2 and no earlier. This covers two synchronizer flops and one flag register.
- R4: After all inputs are good again, `pg_sink` stays 1 for HOLD further cycles, where HOLD = ceil(CLK_HZ × MIN_LOW_NS / 1e9). A rail that is low for one synchronized cycle therefore gives a low pulse of exactly HOLD+1 cycles.
- R5: While `master_on` is 0, `pg_sink` is 1. When it returns to 1, the same stretch as in R4 applies.
- R6: A rail failure while the stretch is running reloads the counter. Release then comes HOLD+1 cycles after the new failure reaches the decision stage.
- R7: `rst_n` low asynchronously forces `pg_sink` to 1. With good inputs held, release comes after rising edge HOLD+3 following reset deassertion.
- R8: Every input passes through a two-flop synchronizer. A low pulse on one rail that lasts a single clock cycle is not filtered out, and it produces the full stretched low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_on | input | 1 | Master enable; low forces not-good |
| rail_good | input | NUM_RAILS (2) | Per-rail comparator flag, 1 = above 89% of nominal |
| pg_sink | output | 1 | Open-drain enable, 1 = pull power-good low |

## Verification
The bench sets CLK_HZ to 250 MHz and MIN_LOW_NS to 40, which makes HOLD ten cycles. With that setting, the exact stretch length, the reload on a repeat failure, and the release after reset can each be counted edge by edge inside a short run. The same arithmetic with the default 10 µs gives a 2500-cycle counter. That case differs only in counter width and is not stepped through.

// File: rtl/pg_pkg.sv
package pg_pkg;
  // Cycles needed to cover a minimum low time, rounded up.
  function automatic int unsigned hold_cycles(input longint unsigned clk_hz,
                                              input longint unsigned low_ns);
    longint unsigned prod;
    prod = clk_hz * low_ns;
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  // Counter width able to hold the value n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async[gi]};
      end
      assign q_sync[gi] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pg_all_good.sv
module pg_all_good #(
  parameter int NUM_RAILS = 2
) (
  input  logic [NUM_RAILS-1:0] rail_ok,
  input  logic                 enable,
  output logic                 all_ok
);
  logic [NUM_RAILS:0] chain;
  assign chain[0] = enable;
  genvar gi;
  generate
    for (gi = 0; gi < NUM_RAILS; gi++) begin : g_and
      assign chain[gi+1] = chain[gi] & rail_ok[gi];
    end
  endgenerate
  assign all_ok = chain[NUM_RAILS];
endmodule

// File: rtl/pg_stretch.sv
module pg_stretch #(
  parameter int unsigned HOLD  = 10,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             all_ok,
  output logic             good,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD);

  logic expired;
  assign expired = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good <= 1'b0;
      cnt  <= LOAD;
    end else if (!all_ok) begin
      good <= 1'b0;
      cnt  <= LOAD;
    end else if (!expired) begin
      good <= 1'b0;
      cnt  <= cnt - 1'b1;
    end else begin
      good <= 1'b1;
    end
  end
endmodule

// File: rtl/pg_monitor.sv
module pg_monitor #(
  parameter longint unsigned CLK_HZ     = 250_000_000,
  parameter longint unsigned MIN_LOW_NS = 10_000,
  parameter int              NUM_RAILS  = 2,
  parameter int              SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 master_on,
  input  logic [NUM_RAILS-1:0] rail_good,
  output logic                 pg_sink
);
  localparam int unsigned HOLD_CYC = pg_pkg::hold_cycles(CLK_HZ, MIN_LOW_NS);
  localparam int unsigned CNT_W    = pg_pkg::cnt_width(HOLD_CYC);

  logic [NUM_RAILS:0]   sync_q;
  logic [NUM_RAILS-1:0] rail_sync;
  logic                 en_sync;
  logic                 rails_ok;
  logic                 flag_good;
  logic [CNT_W-1:0]     stretch_cnt;

  pg_sync #(.WIDTH(NUM_RAILS + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({master_on, rail_good}),
    .q_sync  (sync_q)
  );

  assign rail_sync = sync_q[NUM_RAILS-1:0];
  assign en_sync   = sync_q[NUM_RAILS];

  pg_all_good #(.NUM_RAILS(NUM_RAILS)) u_all (
    .rail_ok (rail_sync),
    .enable  (en_sync),
    .all_ok  (rails_ok)
  );

  pg_stretch #(.HOLD(HOLD_CYC), .CNT_W(CNT_W)) u_stretch (
    .clk    (clk),
    .rst_n  (rst_n),
    .all_ok (rails_ok),
    .good   (flag_good),
    .cnt    (stretch_cnt)
  );

  assign pg_sink = ~flag_good;
endmodule

// File: rtl/pg_monitor_chk.sv
module pg_monitor_chk #(
  parameter int unsigned HOLD  = 10,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rails_ok,
  input logic             en_ok,
  input logic             pg_sink,
  input logic [CNT_W-1:0] cnt
);
  AST_LOW_WHEN_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    !rails_ok |=> pg_sink); // R2

  AST_RELEASE_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pg_sink) |-> ($past(cnt) == '0)); // R4

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (rails_ok && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1))); // R4

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !rails_ok |=> (cnt == CNT_W'(HOLD))); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(HOLD)); // R4

  AST_SHUTDOWN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_ok |=> pg_sink); // R5
endmodule

bind pg_monitor pg_monitor_chk #(.HOLD(HOLD_CYC), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rails_ok(rails_ok),
  .en_ok   (en_sync),
  .pg_sink (pg_sink),
  .cnt     (stretch_cnt)
);

// File: tb/test_pg_monitor.sv
module test_pg_monitor;
  localparam int B_HOLD = (40 * 250) / 1000; // 40 ns at 250 MHz

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master_on = 1'b0;
  logic [1:0] rail_good = 2'b00;
  logic       pg_sink;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  int lowcnt;

  always #2 clk = ~clk;

  pg_monitor #(.CLK_HZ(250_000_000), .MIN_LOW_NS(40)) i_pg_monitor (
    .clk(clk), .rst_n(rst_n), .master_on(master_on),
    .rail_good(rail_good), .pg_sink(pg_sink)
  );

  // table: enable, rails, cycles to wait, expected pg_sink
  localparam int NV = 10;
  localparam bit   V_EN  [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 1};
  localparam bit [1:0] V_RL [NV] = '{2'b11, 2'b01, 2'b11, 2'b10, 2'b11,
                                     2'b00, 2'b11, 2'b11, 2'b11, 2'b11};
  localparam int   V_W   [NV] = '{16, 3, 16, 3, 16, 3, 5, 11, 3, 16};
  localparam bit   V_EXP [NV] = '{0, 1, 0, 1, 0, 1, 1, 0, 1, 0};

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: pg_sink=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic step_count(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      if (pg_sink) lowcnt++;
    end
  endtask

  initial begin
    @(negedge clk);
    #1 check("R7 reset holds line low", pg_sink, 1'b1);
    master_on = 1'b1;
    rail_good = 2'b11;
    rst_n = 1'b1;
    // R7: release after edge HOLD+3
    step(B_HOLD + 2);
    check("R7 still low at edge HOLD+2", pg_sink, 1'b1);
    step(1);
    check("R7 released at edge HOLD+3", pg_sink, 1'b0);

    // table walk covering R1, R2, R5
    for (int i = 0; i < NV; i++) begin
      master_on = V_EN[i];
      rail_good = V_RL[i];
      step(V_W[i]);
      check($sformatf("R2/R5/R1 vector %0d", i), pg_sink, V_EXP[i]);
    end

    // R3 latency: drop before edge 1, low after edge 3
    rail_good = 2'b01;
    step(2);
    check("R3 not yet low after edge 2", pg_sink, 1'b0);
    step(1);
    check("R3 low after edge 3", pg_sink, 1'b1);
    rail_good = 2'b11;
    step(20);
    check("R3 recovered", pg_sink, 1'b0);

    // R8/R4: one-cycle glitch on rail 0 gives exactly HOLD+1 low cycles
    lowcnt = 0;
    rail_good = 2'b10;
    step_count(1);
    rail_good = 2'b11;
    step_count(30);
    check_int("R8 R4 single-cycle glitch low width", lowcnt, B_HOLD + 1);

    // R6: second glitch during stretch reloads the counter
    lowcnt = 0;
    rail_good = 2'b10;
    step_count(1);
    rail_good = 2'b11;
    step_count(5);
    rail_good = 2'b01;
    step_count(1);
    rail_good = 2'b11;
    step_count(40);
    check_int("R6 reload stretches low width", lowcnt, B_HOLD + 7);

    // R7: reset mid-run pulls low at once
    rst_n = 1'b0;
    #1 check("R7 async reset mid-run", pg_sink, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    step(B_HOLD + 3);
    check("R7 release after mid-run reset", pg_sink, 1'b0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule